// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Plane

This block is a reconfigurable AND-OR plane for a programmable-logic fabric. It takes sixteen array signals: eight dedicated inputs and eight feedback lines returned from the output cells. It offers each signal to the plane both as itself and as its inverse. A stored connection map decides which of these 32 literals join each of 64 AND terms. The terms fall into eight groups of eight consecutive terms, and each group drives one output through a fixed OR.

The first term of every group is also brought out on its own, so that an output cell can use it as a buffer enable. A per-group mode input chooses the role of that first term. In one mode it is added to the group's sum along with the other seven. In the other mode it is kept out of the sum, and only the remaining seven terms are ORed.

The map is written serially on the block clock. While the load enable is held, each rising edge shifts in one bit. Term evaluation and the OR sums are purely combinational, working from the array inputs and the stored map.

Top module: `sop_array`

## Requirements
- R1: The map holds 64 rows of 32 columns, and bit k of the loaded stream belongs to term k/32, column k%32. Column 2s is the true form of signal s and column 2s+1 its inverse. Signals 0 to 7 are `ded_in[0..7]` and signals 8 to 15 are `fb_in[0..7]`.
- R2: While `cfg_load_en` is 1, each rising clock edge shifts `cfg_data` into the map. After 2048 such edges the first bit sent sits at term 0, column 0, and the last bit sent sits at term 63, column 31.
- R3: While `cfg_load_en` is 0 the map keeps its contents, whatever `cfg_data` does.
- R4: A term with no columns connected evaluates to 1.
- R5: A term connected to both the true and the inverse column of the same signal evaluates to 0.
- R6: Any other term is the AND of its connected literals.
- R7: Group g is made of terms 8g to 8g+7, and term 8g is its first term. When `grp_mode[g]` is 0, `sum_out[g]` is the OR of all eight terms of the group.
- R8: When `grp_mode[g]` is 1, the first term is left out of `sum_out[g]`, which is then the OR of terms 8g+1 to 8g+7. In both modes `en_term[g]` equals term 8g.
- R9: While `cfg_load_en` is 1, `sum_out` and `en_term` are both all zero.
- R10: An active-low `rst_n` clears every map bit. With a cleared map every term is 1, so `sum_out` and `en_term` read 8'hFF when not loading.
- R11: `sum_out` and `en_term` follow changes on `ded_in`, `fb_in` and `grp_mode` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; it also serves as the shift clock for the map |
| rst_n | input | 1 | Asynchronous reset, active low; clears the map |
| cfg_load_en | input | 1 | Map load enable: shifts on each rising edge and forces the outputs to zero |
| cfg_data | input | 1 | Serial map bit, sent in row-major order starting with term 0 |
| ded_in | input | 8 | Dedicated array inputs (signals 0 to 7) |
| fb_in | input | 8 | Feedback array inputs (signals 8 to 15) |
| grp_mode | input | 8 | Per-group role of the first term: 0 = part of the sum, 1 = enable only |
| sum_out | output | 8 | Per-group OR sum |
| en_term | output | 8 | Per-group first term, exported as an enable |

## Verification
The array results have no register on their path, so `sum_out` and `en_term` are due in the same cycle as any change on `ded_in`, `fb_in` or `grp_mode`. The bench sets those inputs and reads the outputs 1 ns later, with no clock edge counted. A map written through the serial port only takes effect once the 2048th shifting edge has passed. The bench therefore drives each bit on a falling edge and compares outputs only after dropping `cfg_load_en` on the falling edge that follows the final shift. The all-zero output during a load is sampled 1 ns after the load enable has been driven high, in the middle of a stream.

// File: rtl/sop_pkg.sv
`timescale 1ns/1ps
package sop_pkg;

  typedef enum logic {
    FIRST_IN_SUM    = 1'b0,
    FIRST_AS_ENABLE = 1'b1
  } first_term_use_e;

  // One signal's contribution to a product term: a connected literal
  // that is not satisfied forces the term low; both connected forces low.
  function automatic logic literal_ok(input logic use_true,
                                      input logic use_inv,
                                      input logic value);
    logic blocked;
    blocked = (use_true & ~value) | (use_inv & value);
    return ~blocked;
  endfunction

  // Sum of one group, given its first term, the remaining terms and mode.
  function automatic logic group_sum(input logic first,
                                     input logic rest_any,
                                     input first_term_use_e use_sel);
    logic first_part;
    first_part = (use_sel == FIRST_IN_SUM) ? first : 1'b0;
    return first_part | rest_any;
  endfunction

endpackage

// File: rtl/sop_map_store.sv
`timescale 1ns/1ps
module sop_map_store #(
  parameter int MAP_BITS = 2048
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                shift_bit,
  output logic [MAP_BITS-1:0] map
);

  // Shift toward bit 0 so the first bit sent ends at index 0.
  logic [MAP_BITS-1:0] map_q;
  logic [MAP_BITS-1:0] map_shifted;

  assign map_shifted = {shift_bit, map_q[MAP_BITS-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
    end else if (shift_en) begin
      map_q <= map_shifted;
    end
  end

  assign map = map_q;

endmodule

// File: rtl/sop_term_plane.sv
`timescale 1ns/1ps
module sop_term_plane #(
  parameter int N_SIG  = 16,
  parameter int N_TERM = 64,
  localparam int N_COL    = 2 * N_SIG,
  localparam int MAP_BITS = N_COL * N_TERM
) (
  input  logic [N_SIG-1:0]    sig,
  input  logic [MAP_BITS-1:0] map,
  output logic [N_TERM-1:0]   terms
);

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_COL-1:0] row;
    logic             acc;

    assign row = map[t*N_COL +: N_COL];

    always_comb begin
      acc = 1'b1;
      for (int s = 0; s < N_SIG; s++) begin
        acc = acc & sop_pkg::literal_ok(row[2*s], row[2*s+1], sig[s]);
      end
    end

    assign terms[t] = acc;
  end

endmodule

// File: rtl/sop_or_plane.sv
`timescale 1ns/1ps
module sop_or_plane #(
  parameter int N_GRP     = 8,
  parameter int GRP_TERMS = 8,
  localparam int N_TERM   = N_GRP * GRP_TERMS,
  localparam int N_REST   = GRP_TERMS - 1
) (
  input  logic [N_TERM-1:0] terms,
  input  logic [N_GRP-1:0]  mode,
  input  logic              hold_zero,
  output logic [N_GRP-1:0]  first_term,
  output logic [N_GRP-1:0]  rest_any,
  output logic [N_GRP-1:0]  sum,
  output logic [N_GRP-1:0]  en
);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic [N_REST-1:0]         rest;
    logic                      raw_sum;
    sop_pkg::first_term_use_e  use_sel;

    assign first_term[g] = terms[g*GRP_TERMS];
    assign rest          = terms[g*GRP_TERMS+1 +: N_REST];
    assign rest_any[g]   = |rest;
    assign use_sel       = sop_pkg::first_term_use_e'(mode[g]);
    assign raw_sum       = sop_pkg::group_sum(first_term[g], rest_any[g], use_sel);

    assign sum[g] = raw_sum & ~hold_zero;
    assign en[g]  = first_term[g] & ~hold_zero;
  end

endmodule

// File: rtl/sop_array.sv
`timescale 1ns/1ps
module sop_array #(
  parameter int N_DED     = 8,
  parameter int N_GRP     = 8,
  parameter int GRP_TERMS = 8,
  localparam int N_SIG    = N_DED + N_GRP,
  localparam int N_COL    = 2 * N_SIG,
  localparam int N_TERM   = N_GRP * GRP_TERMS,
  localparam int MAP_BITS = N_COL * N_TERM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load_en,
  input  logic             cfg_data,
  input  logic [N_DED-1:0] ded_in,
  input  logic [N_GRP-1:0] fb_in,
  input  logic [N_GRP-1:0] grp_mode,
  output logic [N_GRP-1:0] sum_out,
  output logic [N_GRP-1:0] en_term
);

  // Named internal wires, visible to the bound checker.
  logic [MAP_BITS-1:0] cfg_map;
  logic [N_SIG-1:0]    array_sig;
  logic [N_TERM-1:0]   term_vec;
  logic [N_GRP-1:0]    grp_first;
  logic [N_GRP-1:0]    grp_rest_any;

  assign array_sig = {fb_in, ded_in};

  sop_map_store #(
    .MAP_BITS (MAP_BITS)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (cfg_load_en),
    .shift_bit (cfg_data),
    .map       (cfg_map)
  );

  sop_term_plane #(
    .N_SIG  (N_SIG),
    .N_TERM (N_TERM)
  ) u_terms (
    .sig   (array_sig),
    .map   (cfg_map),
    .terms (term_vec)
  );

  sop_or_plane #(
    .N_GRP     (N_GRP),
    .GRP_TERMS (GRP_TERMS)
  ) u_or (
    .terms      (term_vec),
    .mode       (grp_mode),
    .hold_zero  (cfg_load_en),
    .first_term (grp_first),
    .rest_any   (grp_rest_any),
    .sum        (sum_out),
    .en         (en_term)
  );

endmodule

// File: rtl/sop_array_chk.sv
`timescale 1ns/1ps
module sop_array_chk #(
  parameter int N_DED     = 8,
  parameter int N_GRP     = 8,
  parameter int GRP_TERMS = 8,
  localparam int N_SIG    = N_DED + N_GRP,
  localparam int N_COL    = 2 * N_SIG,
  localparam int N_TERM   = N_GRP * GRP_TERMS,
  localparam int MAP_BITS = N_COL * N_TERM
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_load_en,
  input logic [MAP_BITS-1:0] cfg_map,
  input logic [N_TERM-1:0]   term_vec,
  input logic [N_GRP-1:0]    grp_mode,
  input logic [N_GRP-1:0]    sum_out,
  input logic [N_GRP-1:0]    en_term
);

  // R3: map frozen whenever no load is in progress
  p_map_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load_en |=> $stable(cfg_map));

  // R9: outputs quiet during a load
  p_load_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load_en |-> (sum_out == '0 && en_term == '0));

  for (genvar t = 0; t < N_TERM; t++) begin : g_tchk
    logic [N_COL-1:0] row;
    logic             clash;
    assign row = cfg_map[t*N_COL +: N_COL];
    always_comb begin
      clash = 1'b0;
      for (int s = 0; s < N_SIG; s++) clash = clash | (row[2*s] & row[2*s+1]);
    end
    // R4: empty row is high
    p_empty_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (row == '0) |-> term_vec[t]);
    // R5: true and inverse of one signal gives low
    p_clash_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clash |-> !term_vec[t]);
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_gchk
    logic rest_hit;
    assign rest_hit = |term_vec[g*GRP_TERMS+1 +: GRP_TERMS-1];
    // R8: enable tap follows the first term
    p_enable_tap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load_en |-> (en_term[g] == term_vec[g*GRP_TERMS]));
    // R7: first term reaches the sum in mode 0
    p_first_in_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_load_en && !grp_mode[g] && term_vec[g*GRP_TERMS]) |-> sum_out[g]);
    // R8: first term withheld in mode 1
    p_first_withheld_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_load_en && grp_mode[g] && !rest_hit) |-> !sum_out[g]);
  end

endmodule

bind sop_array sop_array_chk #(
  .N_DED     (N_DED),
  .N_GRP     (N_GRP),
  .GRP_TERMS (GRP_TERMS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_load_en (cfg_load_en),
  .cfg_map     (cfg_map),
  .term_vec    (term_vec),
  .grp_mode    (grp_mode),
  .sum_out     (sum_out),
  .en_term     (en_term)
);

// File: tb/sop_array_test.sv
`timescale 1ns/1ps
module sop_array_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load_en = 1'b0;
  logic       cfg_data = 1'b0;
  logic [7:0] ded_in = '0;
  logic [7:0] fb_in = '0;
  logic [7:0] grp_mode = '0;
  logic [7:0] sum_out;
  logic [7:0] en_term;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [2047:0] tb_map = '0;

  always #10 clk = ~clk;

  sop_array uut (
    .clk(clk), .rst_n(rst_n), .cfg_load_en(cfg_load_en), .cfg_data(cfg_data),
    .ded_in(ded_in), .fb_in(fb_in), .grp_mode(grp_mode),
    .sum_out(sum_out), .en_term(en_term)
  );

  function automatic bit pat_bit(int p, int t, int c);
    if (p == 0) begin
      if (t % 9 == 4) return 1'b0;                    // empty rows (R4)
      if (t % 13 == 5) return (c == 2 || c == 3);     // clash rows (R5)
      return ((t*37 + c*11 + (t/8)*c) % 7) == 0;
    end else if (p == 1) begin
      return c == ((t*5 + t/8) % 32);                 // single literal
    end
    return 1'b1;                                      // every row clashes
  endfunction

  // Model: a term fails if any connected literal disagrees with its signal.
  task automatic model(input logic [7:0] d, input logic [7:0] f, input logic [7:0] m,
                       output logic [7:0] exp_sum, output logic [7:0] exp_en);
    logic [15:0] v;
    v = {f, d};
    exp_sum = '0; exp_en = '0;
    for (int t = 0; t < 64; t++) begin
      int misses = 0;
      for (int s = 0; s < 16; s++) begin
        if (tb_map[t*32 + 2*s]     == 1'b1 && v[s] == 1'b0) misses++;
        if (tb_map[t*32 + 2*s + 1] == 1'b1 && v[s] == 1'b1) misses++;
      end
      if (misses == 0) begin
        if (t % 8 == 0) begin
          exp_en[t/8] = 1'b1;
          if (m[t/8] == 1'b0) exp_sum[t/8] = 1'b1;
        end else begin
          exp_sum[t/8] = 1'b1;
        end
      end
    end
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got en/sum %h expected %h (ded=%h fb=%h mode=%h)",
               req, act, exp, ded_in, fb_in, grp_mode);
    end
  endtask

  task automatic apply(input logic [7:0] d, input logic [7:0] f, input logic [7:0] m,
                       input string req);
    logic [7:0] es, ee;
    ded_in = d; fb_in = f; grp_mode = m;
    #1;
    model(d, f, m, es, ee);
    check(req, {en_term, sum_out}, {ee, es});
  endtask

  task automatic load_pattern(input int p);
    for (int t = 0; t < 64; t++)
      for (int c = 0; c < 32; c++)
        tb_map[t*32 + c] = pat_bit(p, t, c);
    for (int k = 0; k < 2048; k++) begin
      @(negedge clk);
      cfg_load_en = 1'b1;
      cfg_data = tb_map[k];
      if (k == 1000) begin
        #1;
        check("R9 quiet during load", {en_term, sum_out}, 16'h0000);
      end
    end
    @(negedge clk);
    cfg_load_en = 1'b0;
    cfg_data = 1'b0;
  endtask

  task automatic sweep256(input logic [7:0] m, input string req);
    for (int i = 0; i < 256; i++)
      apply(8'(i), 8'(i*29) ^ 8'h5a, m, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: cleared map, every term high
    apply(8'h00, 8'h00, 8'h00, "R10 reset map mode0");
    apply(8'hA7, 8'h3C, 8'hFF, "R10 reset map mode1");

    // Pattern 0: full 16-bit input sweep (R1 R2 R4 R5 R6 R7 R11)
    load_pattern(0);
    for (int i = 0; i < 65536; i++)
      apply(8'(i), 8'(i >> 8), 8'h00, "R1 R2 R4 R5 R6 R7 R11 full sweep");
    sweep256(8'hFF, "R8 first term withheld");
    sweep256(8'hA5, "R7 R8 mixed modes");

    // R3: wiggle data with load low, map must not move
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      cfg_data = 1'(i % 3 == 1);
    end
    cfg_data = 1'b0;
    sweep256(8'h3C, "R3 map held");

    // Pattern 1: one literal per term, checks column order (R1 R2 R6)
    load_pattern(1);
    sweep256(8'h00, "R1 R2 R6 single literal");
    sweep256(8'hFF, "R8 single literal");

    // Pattern 2: all columns set, every term clashes (R5)
    load_pattern(2);
    sweep256(8'h5A, "R5 all clash");

    // R10: reset after loading clears the map again
    load_pattern(0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    tb_map = '0;
    sweep256(8'h96, "R10 reset clears map");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule